// File: doc/BRIEF.md
# Dual-Rail Transition-Coded Serial Word Receiver

This block receives a serial stream sent over four wires: a differential pair that carries the data level and a second differential pair that carries a phase level. Each bit is sent as a change on exactly one of the two pairs. When the new bit equals the previous one, the phase pair toggles. When it differs, the data pair takes the new value. The receiver samples the four wires on its clock. It treats any change in the combined parity of the two pairs as one new bit, and that bit takes the value of the data pair's true rail.

Each bit event advances two structures. The first is a data register that stores the bit levels, with even and odd bits steered into two half-length lanes. The second is a completion register that is cleared when each word starts and is filled with ones. When the one reaches the last position, the assembled word is copied into an output register and a request is raised. The request stays high until the consumer acknowledges it, so the handshake runs once per word and never per bit. A malformed pair sets a sticky error flag and counts no bit. A word that completes while the previous one is still unacknowledged sets a sticky overrun flag.

Top module: `ledr_deser`

## Requirements
- R1: After reset, req_o, word_o, err_o and ovr_o are all zero, and the line is taken as idle with state 0 and phase 0 (state_p=0, state_n=1, phase_p=0, phase_n=1).
- R2: A sampled change of (state_p XOR phase_p) on a well-formed line counts as exactly one bit, and the bit value is state_p.
- R3: The first bit of a word appears at word_o[0], and later bits fill ascending indices up to word_o[WORD_W-1].
- R4: req_o rises only after the WORD_W-th bit of a word. It stays low after WORD_W-1 bits, however long the line then stays quiet. It rises at the second rising clock edge after the pins show the last bit, and each word gives exactly one request.
- R5: Once high, req_o stays high until ack_i is high at a rising edge, and it is low after that edge. word_o holds its value while req_o is pending.
- R6: After a word completes, bit counting restarts, so words sent back to back with no idle cycles are each decoded correctly.
- R7: A sample in which state_p equals state_n or phase_p equals phase_n sets err_o, which then stays high. Such a sample counts no bit.
- R8: A word that completes while req_o is high and ack_i is low sets ovr_o, which then stays high. That word is dropped: word_o keeps the pending word and req_o stays high.
- R9: A sample in which both pairs change at once leaves the parity unchanged and counts no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| state_p | input | 1 | Data pair, true rail |
| state_n | input | 1 | Data pair, complement rail |
| phase_p | input | 1 | Phase pair, true rail |
| phase_n | input | 1 | Phase pair, complement rail |
| ack_i | input | 1 | Consumer acknowledge for the pending word |
| word_o | output | WORD_W | Last accepted parallel word |
| req_o | output | 1 | Word available, held until acknowledged |
| err_o | output | 1 | Sticky malformed-pair flag |
| ovr_o | output | 1 | Sticky overrun flag |

## Verification
If the lane select toggles at the wrong time, or a lane shifts on the wrong event, bits land at the wrong indices. The word handed out by the next request then differs from the expected word, and this shows on the first word after the fault. If the completion register is cleared or loaded wrongly, the request comes one bit early or late. That shows in the cycle-exact latency checks, and every later word in a back-to-back run is misaligned. A mistake in the parity tracking turns a glitch or a double flip into a phantom bit, so the word that contains it fails its comparison.

// File: rtl/ledr_deser_pkg.sv
package ledr_deser_pkg;

   // One sample of the four line wires.
   typedef struct packed {
      logic st_t;
      logic st_f;
      logic ph_t;
      logic ph_f;
   } line_t;

   // Idle line: state 0, phase 0, complements high.
   localparam line_t LINE_IDLE = 4'b0101;

   // Both pairs carry complementary rails.
   function automatic logic line_ok(line_t l);
      return (l.st_t ^ l.st_f) & (l.ph_t ^ l.ph_f);
   endfunction

endpackage

// File: rtl/ledr_edge_det.sv
module ledr_edge_det
   import ledr_deser_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  line_t line_i,
   output logic  shift_o,
   output logic  bit_o,
   output logic  bad_o
);

   line_t smp_q;
   logic  par_q;
   logic  par_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp_q <= LINE_IDLE;
         par_q <= 1'b0;
      end else begin
         smp_q <= line_i;
         if (shift_o) par_q <= par_now;
      end
   end

   always_comb begin
      par_now = smp_q.st_t ^ smp_q.ph_t;
      bad_o   = !line_ok(smp_q);
      shift_o = !bad_o && (par_now != par_q);
      bit_o   = smp_q.st_t;
   end

endmodule

// File: rtl/ledr_data_sr.sv
module ledr_data_sr #(
   parameter int WORD_W   = 8,
   parameter bit TWO_PATH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_i,
   input  logic              bit_i,
   output logic [WORD_W-1:0] word_nxt_o
);

   localparam int HALF_W = WORD_W / 2;

   generate
      if (TWO_PATH) begin : g_split
         logic [HALF_W-1:0] ev_q, ev_d, od_q, od_d;
         logic              sel_q;

         always_comb begin
            ev_d = ev_q;
            od_d = od_q;
            if (shift_i) begin
               if (!sel_q) ev_d = {bit_i, ev_q[HALF_W-1:1]};
               else        od_d = {bit_i, od_q[HALF_W-1:1]};
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ev_q  <= '0;
               od_q  <= '0;
               sel_q <= 1'b0;
            end else begin
               ev_q <= ev_d;
               od_q <= od_d;
               if (shift_i) sel_q <= ~sel_q;
            end
         end

         for (genvar i = 0; i < HALF_W; i++) begin : g_merge
            assign word_nxt_o[2*i]   = ev_d[i];
            assign word_nxt_o[2*i+1] = od_d[i];
         end
      end else begin : g_single
         logic [WORD_W-1:0] sr_q, sr_d;

         always_comb begin
            sr_d = sr_q;
            if (shift_i) sr_d = {bit_i, sr_q[WORD_W-1:1]};
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr_q <= '0;
            else        sr_q <= sr_d;
         end

         assign word_nxt_o = sr_d;
      end
   endgenerate

endmodule

// File: rtl/ledr_comp_sr.sv
module ledr_comp_sr #(
   parameter int WORD_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic shift_i,
   output logic done_o
);

   localparam int FILL_W = WORD_W - 1;

   logic [FILL_W-1:0] fill_q;

   assign done_o = shift_i & fill_q[FILL_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_q <= '0;
      end else if (shift_i) begin
         if (done_o) fill_q <= '0;
         else        fill_q <= {fill_q[FILL_W-2:0], 1'b1};
      end
   end

endmodule

// File: rtl/ledr_deser.sv
module ledr_deser
   import ledr_deser_pkg::*;
#(
   parameter int WORD_W   = 8,
   parameter bit TWO_PATH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              state_p,
   input  logic              state_n,
   input  logic              phase_p,
   input  logic              phase_n,
   input  logic              ack_i,
   output logic [WORD_W-1:0] word_o,
   output logic              req_o,
   output logic              err_o,
   output logic              ovr_o
);

   if (WORD_W < 4) begin : g_bad_width
      $error("ledr_deser: WORD_W must be at least 4");
   end
   if (TWO_PATH && (WORD_W % 2 != 0)) begin : g_bad_split
      $error("ledr_deser: two-lane mode needs an even WORD_W");
   end

   line_t             line;
   logic              shift, bit_val, bad, done, busy;
   logic [WORD_W-1:0] word_nxt;

   assign line = '{st_t: state_p, st_f: state_n, ph_t: phase_p, ph_f: phase_n};

   ledr_edge_det u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_i  (line),
      .shift_o (shift),
      .bit_o   (bit_val),
      .bad_o   (bad)
   );

   ledr_data_sr #(.WORD_W(WORD_W), .TWO_PATH(TWO_PATH)) u_data (
      .clk        (clk),
      .rst_n      (rst_n),
      .shift_i    (shift),
      .bit_i      (bit_val),
      .word_nxt_o (word_nxt)
   );

   ledr_comp_sr #(.WORD_W(WORD_W)) u_comp (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_i (shift),
      .done_o  (done)
   );

   assign busy = req_o & ~ack_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_o <= '0;
         req_o  <= 1'b0;
         err_o  <= 1'b0;
         ovr_o  <= 1'b0;
      end else begin
         req_o <= done | busy;
         if (bad) err_o <= 1'b1;
         if (done) begin
            if (busy) ovr_o  <= 1'b1;
            else      word_o <= word_nxt;
         end
      end
   end

endmodule

// File: rtl/ledr_deser_chk.sv
module ledr_deser_chk #(
   parameter int WORD_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ack_i,
   input logic [WORD_W-1:0] word_o,
   input logic              req_o,
   input logic              err_o,
   input logic              ovr_o,
   input logic              shift
);

   // R4
   req_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_o) |-> $past(shift));

   // R5
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && !ack_i) |=> req_o);

   // R5
   req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_o) |-> $past(ack_i));

   // R8
   word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && !ack_i) |=> $stable(word_o));

   // R7
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> err_o);

   // R8
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_o |=> ovr_o);

   // R8
   ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_o) |-> $past(req_o));

endmodule

bind ledr_deser ledr_deser_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/ledr_deser_test.sv
`timescale 1ns/1ps
module ledr_deser_test;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         state_p = 1'b0, state_n = 1'b1, phase_p = 1'b0, phase_n = 1'b1;
   logic         ack_i = 1'b0;
   logic [W-1:0] word_o;
   logic         req_o, err_o, ovr_o;

   int n_chk = 0, n_fail = 0;
   bit done_flag = 0;
   bit auto_ack = 0;
   logic cur_s = 1'b0, cur_p = 1'b0;
   logic [W-1:0] exp_q[$];

   always #4 clk = ~clk;

   ledr_deser #(.WORD_W(W)) uut (
      .clk(clk), .rst_n(rst_n),
      .state_p(state_p), .state_n(state_n),
      .phase_p(phase_p), .phase_n(phase_n),
      .ack_i(ack_i), .word_o(word_o), .req_o(req_o),
      .err_o(err_o), .ovr_o(ovr_o)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   task automatic put_line();
      state_p = cur_s; state_n = ~cur_s;
      phase_p = cur_p; phase_n = ~cur_p;
   endtask

   // Called at a falling edge; returns at the next falling edge.
   task automatic drive_bit(input logic b);
      if (b == cur_s) cur_p = ~cur_p;
      else            cur_s = b;
      put_line();
      @(negedge clk);
   endtask

   // mode 1: malformed sample after bit 3; mode 2: both pairs flip after bit 3
   task automatic send_word(input logic [W-1:0] w, input int gap, input bit push, input int mode);
      if (push) exp_q.push_back(w);
      for (int i = 0; i < W; i++) begin
         drive_bit(w[i]);
         if (i == 3 && mode == 1) begin
            state_n = state_p;
            @(negedge clk);
            put_line();
         end
         if (i == 3 && mode == 2) begin
            cur_s = ~cur_s; cur_p = ~cur_p;
            put_line();
            @(negedge clk);
         end
         repeat (gap) @(negedge clk);
      end
   endtask

   task automatic do_ack();
      ack_i = 1'b1;
      @(negedge clk);
      ack_i = 1'b0;
   endtask

   // Scoreboard monitor
   always @(negedge clk) begin
      if (auto_ack) begin
         if (ack_i) ack_i = 1'b0;
         else if (req_o) begin
            if (exp_q.size() == 0) check("R4 unexpected word", {24'h0, word_o}, 32'hDEAD);
            else check("R2 R3 R6 word", {24'h0, word_o}, {24'h0, exp_q.pop_front()});
            ack_i = 1'b1;
         end
      end
   end

   initial begin
      #(8 * 20000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 req", req_o, 0);
      check("R1 word", word_o, 0);
      check("R1 err", err_o, 0);
      check("R1 ovr", ovr_o, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4: no request after W-1 bits; exact latency after the last bit
      for (int i = 0; i < W - 1; i++) drive_bit(W'(8'h81) >> i);
      repeat (6) @(negedge clk);
      check("R4 req after W-1 bits", req_o, 0);
      drive_bit(1'b1);
      check("R4 req one edge after last bit", req_o, 0);
      @(negedge clk);
      check("R4 req two edges after last bit", req_o, 1);
      check("R3 word order", word_o, 8'h81);
      do_ack();
      check("R5 req cleared by ack", req_o, 0);

      // Scoreboard phase
      auto_ack = 1;
      send_word(8'h00, 1, 1, 0);
      send_word(8'hFF, 2, 1, 0);
      send_word(8'h55, 0, 1, 0);
      send_word(8'hA5, 3, 1, 0);
      send_word(8'h3C, 0, 1, 0);
      send_word(8'hC3, 0, 1, 0);
      send_word(8'h69, 0, 1, 2);
      repeat (4) @(negedge clk);
      check("R9 no error from double flip", err_o, 0);
      send_word(8'h96, 1, 1, 1);
      repeat (4) @(negedge clk);
      check("R7 err set", err_o, 1);
      send_word(8'h0F, 0, 1, 0);
      repeat (40) @(negedge clk);
      check("R4 R6 all words delivered", exp_q.size(), 0);
      check("R7 err sticky", err_o, 1);
      auto_ack = 0;
      repeat (2) @(negedge clk);

      // R5: request held without ack
      send_word(8'h5A, 0, 0, 0);
      repeat (6) @(negedge clk);
      check("R5 req held", req_o, 1);
      check("R5 word held", word_o, 8'h5A);
      do_ack();
      check("R5 req dropped", req_o, 0);

      // R8: overrun
      check("R8 ovr clear before", ovr_o, 0);
      send_word(8'h12, 0, 0, 0);
      repeat (2) @(negedge clk);
      check("R8 first word pending", req_o, 1);
      send_word(8'h34, 0, 0, 0);
      repeat (2) @(negedge clk);
      check("R8 ovr set", ovr_o, 1);
      check("R8 req still high", req_o, 1);
      check("R8 pending word kept", word_o, 8'h12);
      do_ack();
      check("R8 req after ack", req_o, 0);
      repeat (3) @(negedge clk);
      check("R8 ovr sticky", ovr_o, 1);

      finish_run();
   end

endmodule